// File: doc/BRIEF.md
# Word-Oriented March C- Memory Self-Test Controller

This controller tests a byte-wide synchronous SRAM without a processor. A start pulse launches a fixed schedule of fifteen march elements. The first five elements work on whole words of all-zeros and all-ones and find faults between words. The remaining ten use the checkerboard (0x55/0xAA), pair (0x33/0xCC) and nibble (0x0F/0xF0) backgrounds and find coupling between bits inside one word. The controller drives the address, write data, write strobe and read strobe of the memory under test. It checks every word it reads back against the expected background.

The memory returns read data one cycle after the read strobe, so the controller holds the address through the compare cycle. If a word does not match, the test stops at once. The controller keeps the failing address, the element index, the expected word and the observed word, and raises done with fail. If every word matches, done rises with fail low. Both flags hold until the next start. A start pulse that arrives while a test is running has no effect.

Top module: `mbist_march_top`

## Requirements
- R1: While reset is held and on the first cycle after it, done, fail, busy, mem_we and mem_re are all low.
- R2: The schedule, given as index: order, read word, write word, is:
  - 0: any order, no read, write 00.
  - 1: up, read 00, write FF.
  - 2: up, read FF, write 00.
  - 3: down, read 00, write FF.
  - 4: down, read FF, write 00.
  - 5: down, read 00, write 55.
  - 6: up, read 55, write AA.
  - 7: down, read AA, write 55.
  - 8: up, read 55, write 33.
  - 9: down, read 33, write CC.
  - 10: up, read CC, write 33.
  - 11: down, read 33, write 0F.
  - 12: up, read 0F, write F0.
  - 13: down, read F0, write 0F.
  - 14: up, read 0F, no write.

  Element 0 runs upward.
- R3: An upward element starts at address 0 and ends at 2^ADDR_W-1. A downward element starts at 2^ADDR_W-1 and ends at 0. Each element covers every address before the next element starts.
- R4: For each word, the controller asserts mem_re for one cycle and then spends one compare cycle with no strobe, holding mem_addr. After that it asserts mem_we, unless the element has no write. mem_we and mem_re are never high together.
- R5: A full passing run issues exactly 14 reads and 14 writes per word, 28 operations per word in all.
- R6: A passing run raises done exactly 42*2^ADDR_W clock edges after the edge that samples start.
- R7: On the first mismatch, done and fail rise together and no further memory strobe is issued. fail_addr, fail_elem (element index 0..14 as a 4-bit number), fail_exp and fail_obs then hold the address, element, expected word and observed word of that read.
- R8: When every read matches, done rises with fail low after the last read of element 14.
- R9: done, fail and the captured fields hold while start is low. A start accepted when idle clears done and fail.
- R10: A start pulse while busy is high is ignored: the running test neither restarts nor changes its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test when idle |
| mem_addr | output | ADDR_W | Address to memory under test |
| mem_wdata | output | 8 | Write data to memory |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_rdata | input | 8 | Read data from memory |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_elem | output | 4 | Element index of first mismatch |
| fail_exp | output | 8 | Expected word at first mismatch |
| fail_obs | output | 8 | Observed word at first mismatch |

## Verification
The assertions check the following on every cycle:
- Read and write strobes never overlap.
- Each read is followed by a quiet compare cycle with the address held.
- No strobe is issued once done is high.
- fail never appears without done.
- The result holds until the next start.
- A recorded element index is never 0 and never above 14.

Only the bench's scenarios can show the schedule itself. The bench uses a memory model with injected stuck bits, aliased addresses, a transition fault and bits coupled inside a word. Each fault must be caught in the exact element and at the exact address that the directions and backgrounds predict. The bench also checks the operation count, the run length and the ignored start.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int DATA_W    = 8;
  localparam int ELEM_W    = 4;
  localparam int NUM_ELEMS = 15;
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEMS - 1);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_CMP,
    ST_WR
  } mb_state_e;

  // Address order of an element: 1 = upward, 0 = downward
  function automatic logic elem_up(elem_t e);
    case (e)
      4'd3, 4'd4, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13: elem_up = 1'b0;
      default:                                    elem_up = 1'b1;
    endcase
  endfunction

  // Word expected on the read of an element
  function automatic word_t elem_rexp(elem_t e);
    case (e)
      4'd2, 4'd4:         elem_rexp = 8'hFF;
      4'd6, 4'd8:         elem_rexp = 8'h55;
      4'd7:               elem_rexp = 8'hAA;
      4'd9, 4'd11:        elem_rexp = 8'h33;
      4'd10:              elem_rexp = 8'hCC;
      4'd12, 4'd14:       elem_rexp = 8'h0F;
      4'd13:              elem_rexp = 8'hF0;
      default:            elem_rexp = 8'h00;
    endcase
  endfunction

  // Word written by an element
  function automatic word_t elem_wdat(elem_t e);
    case (e)
      4'd1, 4'd3:         elem_wdat = 8'hFF;
      4'd5, 4'd7:         elem_wdat = 8'h55;
      4'd6:               elem_wdat = 8'hAA;
      4'd8, 4'd10:        elem_wdat = 8'h33;
      4'd9:               elem_wdat = 8'hCC;
      4'd11, 4'd13:       elem_wdat = 8'h0F;
      4'd12:              elem_wdat = 8'hF0;
      default:            elem_wdat = 8'h00;
    endcase
  endfunction

  function automatic logic elem_has_rd(elem_t e);
    elem_has_rd = (e != '0);
  endfunction

  function automatic logic elem_has_wr(elem_t e);
    elem_has_wr = (e != LAST_ELEM);
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_up,
  input  logic              step,
  input  logic              dir_up,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_up ? '0 : ADDR_MAX;
    end else if (step) begin
      addr <= dir_up ? addr + 1'b1 : addr - 1'b1;
    end
  end

  assign last = dir_up ? (addr == ADDR_MAX) : (addr == '0);

endmodule

// File: rtl/mbist_fail_capture.sv
module mbist_fail_capture
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cmp_en,
  input  word_t             exp_word,
  input  word_t             obs_word,
  input  logic [ADDR_W-1:0] addr,
  input  elem_t             elem,
  output logic              mismatch,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output elem_t             fail_elem,
  output word_t             fail_exp,
  output word_t             fail_obs
);

  assign mismatch = cmp_en && (obs_word != exp_word);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr;
      fail_elem <= elem;
      fail_exp  <= exp_word;
      fail_obs  <= obs_word;
    end
  end

endmodule

// File: rtl/mbist_seq_fsm.sv
module mbist_seq_fsm
  import mbist_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  last,
  input  logic  mismatch,
  output logic  load,
  output logic  load_up,
  output logic  step,
  output logic  dir_up,
  output logic  accept,
  output logic  cmp_en,
  output logic  mem_we,
  output logic  mem_re,
  output word_t wdata,
  output word_t exp_word,
  output elem_t elem,
  output logic  busy,
  output logic  done
);

  mb_state_e state;
  elem_t     elem_nx;

  assign elem_nx  = elem + 1'b1;
  assign accept   = (state == ST_IDLE) && start;
  assign dir_up   = elem_up(elem);
  assign load     = accept || ((state == ST_WR) && last);
  assign load_up  = accept ? 1'b1 : elem_up(elem_nx);
  assign step     = ((state == ST_WR) && !last) ||
                    ((state == ST_CMP) && !mismatch && !elem_has_wr(elem) && !last);
  assign cmp_en   = (state == ST_CMP);
  assign mem_we   = (state == ST_WR);
  assign mem_re   = (state == ST_RD);
  assign wdata    = elem_wdat(elem);
  assign exp_word = elem_rexp(elem);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      elem  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_WR;
            elem  <= '0;
            done  <= 1'b0;
          end
        end
        ST_RD: state <= ST_CMP;
        ST_CMP: begin
          if (mismatch) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (elem_has_wr(elem)) begin
            state <= ST_WR;
          end else if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_RD;
          end
        end
        ST_WR: begin
          if (last) begin
            elem  <= elem_nx;
            state <= ST_RD;
          end else begin
            state <= elem_has_rd(elem) ? ST_RD : ST_WR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbist_march_top.sv
module mbist_march_top
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [3:0]        fail_elem,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_obs
);

  logic  load, load_up, step, dir_up, last, accept, cmp_en, mismatch;
  word_t exp_word;
  elem_t elem;

  mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_up (load_up),
    .step    (step),
    .dir_up  (dir_up),
    .addr    (mem_addr),
    .last    (last)
  );

  mbist_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .last     (last),
    .mismatch (mismatch),
    .load     (load),
    .load_up  (load_up),
    .step     (step),
    .dir_up   (dir_up),
    .accept   (accept),
    .cmp_en   (cmp_en),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .wdata    (mem_wdata),
    .exp_word (exp_word),
    .elem     (elem),
    .busy     (busy),
    .done     (done)
  );

  mbist_fail_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .cmp_en    (cmp_en),
    .exp_word  (exp_word),
    .obs_word  (mem_rdata),
    .addr      (mem_addr),
    .elem      (elem),
    .mismatch  (mismatch),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_exp  (fail_exp),
    .fail_obs  (fail_obs)
  );

endmodule

// File: rtl/mbist_march_checker.sv
module mbist_march_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [3:0]        fail_elem
);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_cmp_gap_r4: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we && $stable(mem_addr)));

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re && !busy));

  p_fail_implies_done_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  p_elem_range_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> (fail_elem != 4'd0 && fail_elem <= 4'd14));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_addr) && $stable(fail_elem)));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && !fail && busy));

endmodule

bind mbist_march_top mbist_march_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_elem (fail_elem)
);

// File: tb/mbist_march_top_test.sv
module mbist_march_top_test;

  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int NVEC  = 11;

  // fault kinds in the memory model
  localparam logic [2:0] FK_NONE = 3'd0, FK_STUCK = 3'd1, FK_ALIAS = 3'd2,
                         FK_INTRA = 3'd3, FK_TRANS = 3'd4;

  typedef struct packed {
    logic [2:0] kind;
    logic [3:0] faddr;
    logic [3:0] fpar;
    logic       fval;
    logic       efail;
    logic [3:0] eelem;
    logic [3:0] eaddr;
    logic [7:0] eexp;
    logic [7:0] eobs;
  } vec_t;

  localparam vec_t VECS [0:NVEC-1] = '{
    '{FK_NONE,  4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  4'd0,  8'h00, 8'h00},
    '{FK_STUCK, 4'd5,  4'd0,  1'b1, 1'b1, 4'd1,  4'd5,  8'h00, 8'h01},
    '{FK_STUCK, 4'd15, 4'd6,  1'b1, 1'b1, 4'd1,  4'd15, 8'h00, 8'h40},
    '{FK_STUCK, 4'd9,  4'd7,  1'b0, 1'b1, 4'd2,  4'd9,  8'hFF, 8'h7F},
    '{FK_STUCK, 4'd0,  4'd0,  1'b0, 1'b1, 4'd2,  4'd0,  8'hFF, 8'hFE},
    '{FK_ALIAS, 4'd2,  4'd12, 1'b0, 1'b1, 4'd1,  4'd12, 8'h00, 8'hFF},
    '{FK_ALIAS, 4'd12, 4'd2,  1'b0, 1'b1, 4'd3,  4'd2,  8'h00, 8'hFF},
    '{FK_TRANS, 4'd10, 4'd4,  1'b0, 1'b1, 4'd3,  4'd10, 8'h00, 8'h10},
    '{FK_INTRA, 4'd7,  4'd1,  1'b0, 1'b1, 4'd6,  4'd7,  8'h55, 8'h57},
    '{FK_INTRA, 4'd7,  4'd2,  1'b0, 1'b1, 4'd9,  4'd7,  8'h33, 8'h37},
    '{FK_INTRA, 4'd7,  4'd4,  1'b0, 1'b1, 4'd12, 4'd7,  8'h0F, 8'h1F}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          mem_we, mem_re, busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [3:0]    fail_elem;
  logic [7:0]    fail_exp, fail_obs;

  always #5 clk = ~clk;

  mbist_march_top #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  // memory model with fault injection, one-cycle read latency
  logic [2:0] f_kind = FK_NONE;
  logic [3:0] f_addr = '0, f_par = '0;
  logic       f_val  = 1'b0;
  logic       clr_mem = 1'b0;
  logic [7:0] mem [0:WORDS-1];
  logic [7:0] nw;

  always_comb begin
    nw = mem_wdata;
    if (mem_addr == f_addr) begin
      if (f_kind == FK_INTRA) nw[f_par[2:0]] = mem_wdata[0];
      if (f_kind == FK_TRANS && mem[mem_addr][f_par[2:0]]) nw[f_par[2:0]] = 1'b1;
      if (f_kind == FK_STUCK) nw[f_par[2:0]] = f_val;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_mem) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
    end else if (mem_we) begin
      mem[mem_addr] <= nw;
      if (f_kind == FK_ALIAS && mem_addr == f_addr) mem[f_par] <= nw;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // operation counters
  int n_we = 0, n_re = 0;
  always_ff @(posedge clk) begin
    if (clr_mem) begin
      n_we <= 0;
      n_re <= 0;
    end else begin
      if (mem_we) n_we <= n_we + 1;
      if (mem_re) n_re <= n_re + 1;
    end
  end

  int tests = 0, fails = 0;
  int cyc_total = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one test; returns edges from start edge to done; kick>0 pulses start mid-run
  task automatic run(output int cycles, input int kick);
    @(negedge clk) clr_mem = 1'b1;
    @(negedge clk) clr_mem = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      if (kick > 0 && cycles == kick) start = 1'b1;
      else start = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {done, fail, busy, mem_we, mem_re}, 0);

    // vector table: fault location and kind -> element and address of first failure (R2, R3, R7)
    for (int v = 0; v < NVEC; v++) begin
      f_kind = VECS[v].kind;
      f_addr = VECS[v].faddr;
      f_par  = VECS[v].fpar;
      f_val  = VECS[v].fval;
      run(cyc, 0);
      chk("R7 done", done, 1);
      chk("R7 fail flag", fail, VECS[v].efail);
      if (VECS[v].efail) begin
        chk("R3 fail_addr", fail_addr, VECS[v].eaddr);
        chk("R2 fail_elem", fail_elem, VECS[v].eelem);
        chk("R2 fail_exp", fail_exp, VECS[v].eexp);
        chk("R7 fail_obs", fail_obs, VECS[v].eobs);
      end else begin
        chk("R8 pass", {done, fail}, 2'b10);
        chk("R6 run length", cyc, 42 * WORDS);
        chk("R5 writes", n_we, 14 * WORDS);
        chk("R5 reads", n_re, 14 * WORDS);
        chk("R4 ops per word", n_we + n_re, 28 * WORDS);
      end
      // R9 result holds without start
      repeat (4) @(negedge clk);
      chk("R9 hold done", done, 1);
      chk("R9 hold fail", fail, VECS[v].efail);
    end

    // R10: start while busy is ignored; R9: prior fail cleared by new start
    f_kind = FK_NONE;
    run(cyc, 100);
    chk("R10 length unchanged", cyc, 42 * WORDS);
    chk("R10 pass", {done, fail}, 2'b10);
    chk("R9 fail cleared", fail, 0);
    chk("R10 ops unchanged", n_we + n_re, 28 * WORDS);

    // R9: start after done clears done
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 done cleared", done, 0);
    chk("R9 busy", busy, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule